// File: doc/BRIEF.md
# Colour Look-Up Table with Sequenced Data Port

This block holds a 256-entry colour table. Each entry has three 6-bit components, red, green and blue. Software reaches the table through two index registers and one shared data port. A load of the read index or the write index sets the matching pointer and returns its component counter to red. Each access on the data port then handles one component and steps the counter. After the blue component, the pointer moves to the next entry. The read pointer and the write pointer step independently of each other.

A separate pixel port runs alongside the data port. A pixel index presented on it returns the committed colour of that entry as a packed 24-bit word, one clock later. An entry's committed colour changes only when the blue component of a write triple arrives. A half-written entry therefore never reaches the pixel output. Each 6-bit component is widened to 8 bits: the component is shifted left by two and its least significant bit is copied into both new low bits.

Top module: `colour_lut_port`

## Requirements
- R1: After reset, entry i for i in 0..15 holds red = 0x2A if i[2] else 0, green = 0x2A if i[1] else 0, and blue = (0x2A if i[0] else 0) + (0x15 if i[3] else 0). Entries 16..255 hold zero. Both pointers and both component counters are zero, and rdata_o is zero.
- R2: A cycle with rd_idx_we_i high loads wdata_i into the read pointer and resets the read component counter to red, even partway through a triple.
- R3: A cycle with wr_idx_we_i high loads wdata_i into the write pointer and resets the write component counter to red, even partway through a triple.
- R4: A cycle with data_re_i high places the component selected by the read counter on rdata_o after that clock edge, in the order red, green, blue. The counter then advances, and after blue the read pointer increments by one.
- R5: A cycle with data_we_i high stores wdata_i[5:0] as the component selected by the write counter. The counter then advances, and after blue the write pointer increments by one.
- R6: The committed colour of an entry changes only in the cycle its blue component is written. Writing only red and green leaves the pixel output for that entry unchanged.
- R7: pix_rgb_o carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each byte is {c[5:0], c[0], c[0]}.
- R8: pix_rgb_o is registered. It shows the colour of the index that was present on pix_idx_i at the previous rising edge.
- R9: Both pointers wrap from 255 to 0 when they step past the last entry.
- R10: wdata_i bits 7:6 have no effect on a stored component.
- R11: Data-port reads do not move the write pointer or the write counter, and writes do not move the read pointer or the read counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_we_i | input | 1 | Load the read pointer from wdata_i |
| wr_idx_we_i | input | 1 | Load the write pointer from wdata_i |
| data_we_i | input | 1 | Write one component from wdata_i |
| data_re_i | input | 1 | Read one component to rdata_o |
| wdata_i | input | 8 | Shared bus for index loads and component writes |
| rdata_o | output | 6 | Last component read from the data port |
| pix_idx_i | input | 8 | Pixel lookup index |
| pix_rgb_o | output | 24 | Packed, widened colour of the looked-up entry |

## Verification
A component counter that is off by one shows at the ports on the very next data access. The wrong channel appears on rdata_o, or a committed colour comes out with its bytes rotated. A pointer that steps at the wrong moment, or that is moved by the other direction's traffic, shows up on the first pixel lookup of the entry that should have been written, and on the next triple read. A commit that fires early shows as a pixel change after only the red or green write. The bench therefore looks up the pixel between the component writes, not only after them.

// File: rtl/colour_lut_pkg.sv
package colour_lut_pkg;

  typedef enum logic [1:0] {
    SUB_R = 2'd0,
    SUB_G = 2'd1,
    SUB_B = 2'd2
  } sub_e;

  // Standard 16-colour set, channel 0 = red, 1 = green, 2 = blue
  function automatic logic [5:0] std_comp(input int e, input int ch);
    logic [5:0] v;
    v = 6'h00;
    if (e < 16) begin
      case (ch)
        0:       v = ((e >> 2) & 1) != 0 ? 6'h2A : 6'h00;
        1:       v = ((e >> 1) & 1) != 0 ? 6'h2A : 6'h00;
        default: v = (((e & 1) != 0) ? 6'h2A : 6'h00) + ((((e >> 3) & 1) != 0) ? 6'h15 : 6'h00);
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/lut_idx_seq.sv
module lut_idx_seq
  import colour_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output sub_e             sub_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;
  sub_e             sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sub_q <= SUB_R;
    end else if (load_i) begin
      idx_q <= load_val_i;
      sub_q <= SUB_R;
    end else if (step_i) begin
      if (sub_q == SUB_B) begin
        sub_q <= SUB_R;
        idx_q <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_e'(sub_q + 2'd1);
      end
    end
  end

  assign idx_o = idx_q;
  assign sub_o = sub_q;

  p_load_r2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_o == $past(load_val_i)) && (sub_o == SUB_R));

  p_sub_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o != 2'd3);

  p_hold_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && sub_o != SUB_B) |=> $stable(idx_o));

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && sub_o == SUB_B && idx_o == IDX_MAX) |=> (idx_o == '0));

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(idx_o) && $stable(sub_o)));

endmodule

// File: rtl/lut_store.sv
module lut_store
  import colour_lut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 6,
  parameter int DEF_CNT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  sub_e                wr_sub_i,
  input  logic [COMP_W-1:0]   wr_data_i,
  input  logic                re_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  input  sub_e                rd_sub_i,
  output logic [COMP_W-1:0]   rd_data_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_comp_o
);

  localparam int TRI_W = 3 * COMP_W;

  // comp_q follows every write; live_q only takes whole triples
  logic [TRI_W-1:0]  comp_q [ENTRIES];
  logic [TRI_W-1:0]  live_q [ENTRIES];
  logic [COMP_W-1:0] rd_data_q;
  logic [TRI_W-1:0]  pix_q;
  logic              commit;

  assign commit = we_i && (wr_sub_i == SUB_B);

  function automatic logic [TRI_W-1:0] reset_triple(input int e);
    if (e < DEF_CNT)
      return {COMP_W'(std_comp(e, 0)), COMP_W'(std_comp(e, 1)), COMP_W'(std_comp(e, 2))};
    return '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        comp_q[e] <= reset_triple(e);
        live_q[e] <= reset_triple(e);
      end
    end else if (we_i) begin
      case (wr_sub_i)
        SUB_R:   comp_q[wr_idx_i][TRI_W-1:2*COMP_W]    <= wr_data_i;
        SUB_G:   comp_q[wr_idx_i][2*COMP_W-1:COMP_W]   <= wr_data_i;
        default: comp_q[wr_idx_i][COMP_W-1:0]          <= wr_data_i;
      endcase
      if (commit)
        live_q[wr_idx_i] <= {comp_q[wr_idx_i][TRI_W-1:COMP_W], wr_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
    end else if (re_i) begin
      case (rd_sub_i)
        SUB_R:   rd_data_q <= comp_q[rd_idx_i][TRI_W-1:2*COMP_W];
        SUB_G:   rd_data_q <= comp_q[rd_idx_i][2*COMP_W-1:COMP_W];
        default: rd_data_q <= comp_q[rd_idx_i][COMP_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= live_q[pix_idx_i];
  end

  assign rd_data_o  = rd_data_q;
  assign pix_comp_o = pix_q;

  p_rdata_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rd_data_o));

endmodule

// File: rtl/lut_expand.sv
module lut_expand #(
  parameter int COMP_W = 6,
  parameter int OUT_W  = 8
) (
  input  logic [3*COMP_W-1:0] comp_i,
  output logic [3*OUT_W-1:0]  rgb_o
);

  localparam int FILL_W = OUT_W - COMP_W;

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [COMP_W-1:0] c;
    assign c = comp_i[ch*COMP_W +: COMP_W];
    if (FILL_W > 0) begin : g_fill
      assign rgb_o[ch*OUT_W +: OUT_W] = {c, {FILL_W{c[0]}}};
    end else begin : g_trunc
      assign rgb_o[ch*OUT_W +: OUT_W] = c[COMP_W-1 -: OUT_W];
    end
  end

endmodule

// File: rtl/colour_lut_port.sv
module colour_lut_port
  import colour_lut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int BUS_W   = 8,
  parameter int COMP_W  = 6,
  parameter int OUT_W   = 8,
  parameter int DEF_CNT = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_idx_we_i,
  input  logic               wr_idx_we_i,
  input  logic               data_we_i,
  input  logic               data_re_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [COMP_W-1:0]  rdata_o,
  input  logic [IDX_W-1:0]   pix_idx_i,
  output logic [3*OUT_W-1:0] pix_rgb_o
);

  logic [IDX_W-1:0]    rd_idx, wr_idx;
  sub_e                rd_sub, wr_sub;
  logic [3*COMP_W-1:0] pix_comp;
  logic                unused_bus_hi;

  // Only the low COMP_W bits reach the table
  assign unused_bus_hi = ^wdata_i[BUS_W-1:COMP_W];

  lut_idx_seq #(.IDX_W(IDX_W)) u_rd_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_idx_we_i),
    .load_val_i (wdata_i[IDX_W-1:0]),
    .step_i     (data_re_i),
    .idx_o      (rd_idx),
    .sub_o      (rd_sub)
  );

  lut_idx_seq #(.IDX_W(IDX_W)) u_wr_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_idx_we_i),
    .load_val_i (wdata_i[IDX_W-1:0]),
    .step_i     (data_we_i),
    .idx_o      (wr_idx),
    .sub_o      (wr_sub)
  );

  lut_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .COMP_W  (COMP_W),
    .DEF_CNT (DEF_CNT)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (data_we_i),
    .wr_idx_i   (wr_idx),
    .wr_sub_i   (wr_sub),
    .wr_data_i  (wdata_i[COMP_W-1:0]),
    .re_i       (data_re_i),
    .rd_idx_i   (rd_idx),
    .rd_sub_i   (rd_sub),
    .rd_data_o  (rdata_o),
    .pix_idx_i  (pix_idx_i),
    .pix_comp_o (pix_comp)
  );

  lut_expand #(.COMP_W(COMP_W), .OUT_W(OUT_W)) u_expand (
    .comp_i (pix_comp),
    .rgb_o  (pix_rgb_o)
  );

  // One edge since reset must pass before $past is meaningful
  logic arm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= 1'b1;
  end

  p_no_partial_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && $stable(pix_idx_i) && !$past(data_we_i && wr_sub == SUB_B))
      |=> $stable(pix_rgb_o));

  p_ptr_split_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && !data_we_i && !wr_idx_we_i) |=> ($stable(wr_idx) && $stable(wr_sub)));

endmodule

// File: tb/colour_lut_port_bench.sv
module colour_lut_port_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_idx_we = 1'b0, wr_idx_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [5:0]  rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  colour_lut_port u_colour_lut_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rd_idx_we_i (rd_idx_we),
    .wr_idx_we_i (wr_idx_we),
    .data_we_i   (data_we),
    .data_re_i   (data_re),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .pix_idx_i   (pix_idx),
    .pix_rgb_o   (pix_rgb)
  );

  // {index, red, green, blue}; upper bus bits set in some components
  localparam logic [31:0] VEC [8] = '{
    32'h10_3F_00_15, 32'h11_01_02_03, 32'h64_2A_15_3F, 32'h80_C5_7F_80,
    32'hC8_10_20_30, 32'hFE_3F_3F_3F, 32'h07_00_00_01, 32'h2A_E1_52_B3
  };

  function automatic logic [7:0] wid(input logic [5:0] c);
    return {c, c[0], c[0]};
  endfunction

  function automatic logic [23:0] pack(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
    return {wid(r), wid(g), wid(b)};
  endfunction

  function automatic logic [23:0] std_rgb(input int i);
    logic [5:0] r, g, b;
    r = i[2] ? 6'h2A : 6'h00;
    g = i[1] ? 6'h2A : 6'h00;
    b = (i[0] ? 6'h2A : 6'h00) + (i[3] ? 6'h15 : 6'h00);
    return pack(r, g, b);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic ld_rd(input logic [7:0] v);
    rd_idx_we = 1'b1; wdata = v;
    @(negedge clk);
    rd_idx_we = 1'b0;
  endtask

  task automatic ld_wr(input logic [7:0] v);
    wr_idx_we = 1'b1; wdata = v;
    @(negedge clk);
    wr_idx_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] v);
    data_we = 1'b1; wdata = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic get(output logic [5:0] v);
    data_re = 1'b1;
    @(negedge clk);
    data_re = 1'b0;
    v = rdata;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] c);
    pix_idx = i;
    @(negedge clk);
    c = pix_rgb;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [23:0] c;
    logic [5:0]  d;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 rdata reset", 32'(rdata), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      look(8'(i), c);
      chk("R1 default colour", 32'(c), 32'(std_rgb(i)));
    end
    look(8'd16, c);  chk("R1 entry16 zero", 32'(c), 32'h0);
    look(8'd255, c); chk("R1 entry255 zero", 32'(c), 32'h0);
    get(d); chk("R1 read ptr 0 red", 32'(d), 32'h00);
    get(d); chk("R1 read ptr 0 green", 32'(d), 32'h00);
    get(d); chk("R1 read ptr 0 blue", 32'(d), 32'h00);
    ld_rd(8'd9);
    get(d); chk("R4 entry9 red", 32'(d), 32'h00);
    get(d); chk("R4 entry9 green", 32'(d), 32'h00);
    get(d); chk("R4 entry9 blue", 32'(d), 32'h3F);

    // Table walk: R5 R7 R10 on write, R4 on read back
    for (int k = 0; k < 8; k++) begin
      logic [7:0] ix, r, g, b;
      {ix, r, g, b} = VEC[k];
      ld_wr(ix); put(r); put(g); put(b);
      look(ix, c);
      chk("R7 R10 packed colour", 32'(c), 32'(pack(r[5:0], g[5:0], b[5:0])));
      ld_rd(ix);
      get(d); chk("R4 R10 read red", 32'(d), 32'(r[5:0]));
      get(d); chk("R4 read green", 32'(d), 32'(g[5:0]));
      get(d); chk("R4 read blue", 32'(d), 32'(b[5:0]));
    end

    // R8: registered lookup
    look(8'd3, c);
    pix_idx = 8'd9;
    #1;
    chk("R8 old colour before edge", 32'(pix_rgb), 32'(std_rgb(3)));
    @(negedge clk);
    chk("R8 new colour after edge", 32'(pix_rgb), 32'(std_rgb(9)));

    // R6: no commit before blue
    ld_wr(8'd5); put(8'h11);
    look(8'd5, c); chk("R6 after red only", 32'(c), 32'(std_rgb(5)));
    put(8'h22);
    look(8'd5, c); chk("R6 after green", 32'(c), 32'(std_rgb(5)));
    put(8'h33);
    look(8'd5, c); chk("R6 after blue", 32'(c), 32'(pack(6'h11, 6'h22, 6'h33)));

    // R9: write pointer wrap
    ld_wr(8'd255);
    put(8'h01); put(8'h02); put(8'h03);
    put(8'h04); put(8'h05); put(8'h06);
    look(8'd255, c); chk("R9 entry255", 32'(c), 32'(pack(6'h01, 6'h02, 6'h03)));
    look(8'd0, c);   chk("R9 wrapped to entry0", 32'(c), 32'(pack(6'h04, 6'h05, 6'h06)));
    // R9: read pointer wrap
    ld_rd(8'd255);
    get(d); get(d); get(d);
    chk("R9 read entry255 blue", 32'(d), 32'h03);
    get(d); chk("R9 read wrap entry0 red", 32'(d), 32'h04);

    // R11: reads interleaved with a write triple
    ld_wr(8'd50); put(8'h0A);
    ld_rd(8'd0);
    get(d); chk("R11 read red", 32'(d), 32'h04);
    get(d); chk("R11 read green", 32'(d), 32'h05);
    put(8'h0B);
    get(d); chk("R11 read blue", 32'(d), 32'h06);
    put(8'h0C);
    look(8'd50, c); chk("R11 write seq intact", 32'(c), 32'(pack(6'h0A, 6'h0B, 6'h0C)));
    get(d); chk("R11 read seq intact", 32'(d), 32'h00);

    // R2: read index reload mid-triple
    ld_rd(8'd17);
    get(d);
    ld_rd(8'd17);
    get(d); chk("R2 reload restarts at red", 32'(d), 32'h01);

    // R3: write index reload mid-triple
    ld_wr(8'd60); put(8'h2F);
    ld_wr(8'd61); put(8'h07); put(8'h08); put(8'h09);
    look(8'd61, c); chk("R3 reload restarts at red", 32'(c), 32'(pack(6'h07, 6'h08, 6'h09)));
    look(8'd60, c); chk("R3 abandoned entry uncommitted", 32'(c), 32'h0);

    report();
    $finish;
  end

endmodule